// File: doc/BRIEF.md
# Message Signaled Interrupt Generator

This block keeps the message-interrupt capability registers of a PCI-style device. It turns device interrupt requests into single memory-write messages. Software sets up the block through a small configuration port: one control word, a message address and a message data word. Device logic raises bits of a request vector. Each raised bit becomes pending. When messages are enabled, the pending requests are sent one at a time on a simple master write channel (valid, ready, address, data). The processor sends nothing back.

The number of messages that software enables decides how many distinct vectors the device can use. When more than one message is enabled, the index of the request source replaces the low bits of the vector. Sources whose index lies beyond the enabled range share the last enabled message. The legacy pin interrupt path is represented only by a disable output, which is high whenever messages are enabled.

Top module: `msi_gen`

## Requirements
- R1: Reading the control word (select 0) returns bit 0 = message enable, bits 3:1 = capability count code (parameter `CAP_CODE`, read-only), bits 6:4 = enabled count code, bit 7 = 64-bit capability (parameter `CAP_64`, read-only), and zero in bits 31:8. After reset, enable and enabled count are 0.
- R2: A written enabled-count code that is larger than `CAP_CODE` is stored as `CAP_CODE`. This includes the reserved codes 6 and 7. Count codes are log2 encoded: code k means 2^k messages.
- R3: The low address word (select 1) always reads 0xFEE in bits 31:20. Bits 19:12 (destination), bit 3 (redirection hint) and bit 2 (destination mode) can be written. All other bits read zero. Every message carries these same bits in its address bits 31:0.
- R4: With `CAP_64` = 1, the high address word (select 2) is a full 32-bit read/write register and forms message address bits 63:32. With `CAP_64` = 0, it reads zero, ignores writes, and message address bits 63:32 are zero.
- R5: The data word (select 3) stores bits 15 (trigger mode), 14 (trigger level), 10:8 (delivery mode) and 7:0 (vector). All other bits read zero.
- R6: No message is issued while enable is 0. Requests raised during that time stay pending and are sent after enable is set.
- R7: Pending sources are served lowest index first, with exactly one write per request. While valid is high and ready is low, valid, address and data hold steady. A pending bit clears only when its write is accepted.
- R8: With 2^k messages enabled, the low k bits of the vector are replaced by the source index. An index of 2^k or more is replaced by 2^k - 1.
- R9: The message data word equals the stored data word with the vector replaced as in R8, and bits 31:16 are zero.
- R10: The legacy interrupt disable output equals the message enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_sel | input | 2 | Register select: 0 control, 1 address low, 2 address high, 3 data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for the selected register |
| irq_req | input | NUM_SRC | Interrupt requests; a high bit in any cycle marks that source pending |
| wr_valid | output | 1 | Message write request |
| wr_ready | input | 1 | Bus accepts the message write |
| wr_addr | output | 64 | Message address |
| wr_data | output | 32 | Message data |
| intx_disable | output | 1 | Legacy pin interrupt disable |

## Verification
The main instance is built with eight sources, a capability of four messages and 64-bit addressing. With these values the bench can reach the case where sources 4 to 7 fold onto the last message, and also the case where a narrower count of two messages is set. A second instance is built with two sources, one message and 32-bit addressing only, so that the read-zero, write-ignored upper address can be observed. Ready follows a repeating stall pattern, and at one point it is held low for several cycles to exercise the hold rule.

// File: rtl/msi_pkg.sv
package msi_pkg;

  localparam int VEC_W = 8;

  // clamp a requested count code to the capability code
  function automatic logic [2:0] clamp_count(input logic [2:0] req, input logic [2:0] cap);
    return (req > cap) ? cap : req;
  endfunction

  // replace low bits of the vector with the (folded) source index
  function automatic logic [VEC_W-1:0] merge_vector(input logic [VEC_W-1:0] vec,
                                                    input logic [VEC_W-1:0] idx,
                                                    input logic [2:0]       cnt_code);
    logic [VEC_W-1:0] low_mask;
    logic [VEC_W-1:0] eff;
    low_mask = (VEC_W'(1) << cnt_code) - VEC_W'(1);
    eff      = (idx > low_mask) ? low_mask : idx;
    return (vec & ~low_mask) | eff;
  endfunction

endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
  import msi_pkg::*;
#(
  parameter logic [2:0] CAP_CODE = 3'd3,
  parameter bit         CAP_64   = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  sel,
  input  logic        we,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        msi_en,
  output logic [2:0]  cnt_code,
  output logic [63:0] msg_addr,
  output logic [15:0] data_base
);
  localparam logic [11:0] ADDR_TOP = 12'hFEE;

  logic [7:0]  dest_q;
  logic        hint_q, mode_q;
  logic        tmode_q, tlevel_q;
  logic [2:0]  dmode_q;
  logic [7:0]  vec_q;
  logic [31:0] hi_q;
  logic [31:0] ctl_word, lo_word, data_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msi_en   <= 1'b0;
      cnt_code <= 3'd0;
      dest_q   <= '0;
      hint_q   <= 1'b0;
      mode_q   <= 1'b0;
      tmode_q  <= 1'b0;
      tlevel_q <= 1'b0;
      dmode_q  <= '0;
      vec_q    <= '0;
    end else if (we) begin
      case (sel)
        2'd0: begin
          msi_en   <= wdata[0];
          cnt_code <= clamp_count(wdata[6:4], CAP_CODE);
        end
        2'd1: begin
          dest_q <= wdata[19:12];
          hint_q <= wdata[3];
          mode_q <= wdata[2];
        end
        2'd3: begin
          tmode_q  <= wdata[15];
          tlevel_q <= wdata[14];
          dmode_q  <= wdata[10:8];
          vec_q    <= wdata[7:0];
        end
        default: ;
      endcase
    end
  end

  generate
    if (CAP_64) begin : g_hi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 hi_q <= '0;
        else if (we && sel == 2'd2) hi_q <= wdata;
      end
    end else begin : g_no_hi
      assign hi_q = '0;
    end
  endgenerate

  assign ctl_word  = {24'd0, CAP_64, cnt_code, CAP_CODE, msi_en};
  assign lo_word   = {ADDR_TOP, dest_q, 8'd0, hint_q, mode_q, 2'b00};
  assign data_word = {16'd0, tmode_q, tlevel_q, 3'd0, dmode_q, vec_q};

  always_comb begin
    case (sel)
      2'd0:    rdata = ctl_word;
      2'd1:    rdata = lo_word;
      2'd2:    rdata = hi_q;
      default: rdata = data_word;
    endcase
  end

  assign msg_addr  = {hi_q, lo_word};
  assign data_base = data_word[15:0];
endmodule

// File: rtl/msi_pick.sv
module msi_pick #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] pend,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend[i]) idx = IDX_W'(i);
    end
  end
  assign any = |pend;
endmodule

// File: rtl/msi_gen.sv
module msi_gen
  import msi_pkg::*;
#(
  parameter int         NUM_SRC  = 8,
  parameter logic [2:0] CAP_CODE = 3'd3,
  parameter bit         CAP_64   = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         cfg_sel,
  input  logic               cfg_we,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic [NUM_SRC-1:0] irq_req,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [63:0]        wr_addr,
  output logic [31:0]        wr_data,
  output logic               intx_disable
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic               msi_en;
  logic [2:0]         cnt_code;
  logic [63:0]        msg_addr;
  logic [15:0]        data_base;
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] clr_mask;
  logic               pick_any;
  logic [IDX_W-1:0]   pick_idx;
  logic [IDX_W-1:0]   cur_idx;
  logic               launch;   // a new message is loaded this cycle
  logic               accept;   // the bus takes the current message

  msi_cfg_regs #(.CAP_CODE(CAP_CODE), .CAP_64(CAP_64)) u_regs (
    .clk, .rst_n,
    .sel(cfg_sel), .we(cfg_we), .wdata(cfg_wdata), .rdata(cfg_rdata),
    .msi_en, .cnt_code, .msg_addr, .data_base
  );

  msi_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .pend(pend_q), .any(pick_any), .idx(pick_idx)
  );

  assign launch = !wr_valid && msi_en && pick_any;
  assign accept = wr_valid && wr_ready;

  always_comb begin
    clr_mask = '0;
    if (accept) clr_mask[cur_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_mask) | irq_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      cur_idx  <= '0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else if (launch) begin
      wr_valid <= 1'b1;
      cur_idx  <= pick_idx;
      wr_addr  <= msg_addr;
      wr_data  <= {16'd0, data_base[15:8],
                   merge_vector(data_base[7:0], VEC_W'(pick_idx), cnt_code)};
    end else if (accept) begin
      wr_valid <= 1'b0;
    end
  end

  assign intx_disable = msi_en;
endmodule

// File: rtl/msi_gen_chk.sv
module msi_gen_chk #(
  parameter logic [2:0] CAP_CODE = 3'd3,
  parameter bit         CAP_64   = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [63:0] wr_addr,
  input logic [31:0] wr_data,
  input logic        msi_en,
  input logic [2:0]  cnt_code,
  input logic        accept
);
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R7
  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !wr_valid); // R7
  AST_NO_SEND_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(msi_en)); // R6
  AST_ADDR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_addr[31:20] == 12'hFEE && wr_addr[1:0] == 2'b00); // R3
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !CAP_64 |-> wr_addr[63:32] == 32'd0); // R4
  AST_DATA_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_data[31:16] == 16'd0 && wr_data[13:11] == 3'd0); // R9
  AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_code <= CAP_CODE); // R2
endmodule

bind msi_gen msi_gen_chk #(.CAP_CODE(CAP_CODE), .CAP_64(CAP_64)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .msi_en(msi_en),
  .cnt_code(cnt_code), .accept(accept)
);

// File: tb/msi_gen_test.sv
`timescale 1ns/1ps
module msi_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata, rdata32;
  logic [7:0]  irq_req = '0;
  logic        wr_valid, wr_ready = 1'b0;
  logic [63:0] wr_addr;
  logic [31:0] wr_data;
  logic        intx_disable;
  logic        v32, intx32;
  logic [63:0] a32;
  logic [31:0] d32;

  int checks = 0, errors = 0, seen = 0, cyc = 0;
  bit stall = 1'b0;
  logic [95:0] expq[$];

  always #10 clk = ~clk;

  msi_gen #(.NUM_SRC(8), .CAP_CODE(3'd2), .CAP_64(1'b1)) uut (
    .clk, .rst_n, .cfg_sel, .cfg_we, .cfg_wdata, .cfg_rdata, .irq_req,
    .wr_valid, .wr_ready, .wr_addr, .wr_data, .intx_disable);

  msi_gen #(.NUM_SRC(2), .CAP_CODE(3'd0), .CAP_64(1'b0)) uut32 (
    .clk, .rst_n, .cfg_sel, .cfg_we, .cfg_wdata, .cfg_rdata(rdata32),
    .irq_req(2'b00), .wr_valid(v32), .wr_ready(1'b1), .wr_addr(a32),
    .wr_data(d32), .intx_disable(intx32));

  task automatic check(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // ready pattern, updated just after each rising edge
  always begin
    @(posedge clk); #1;
    cyc++;
    wr_ready = !stall && (cyc % 3 != 2);
  end

  // monitor: compare each accepted write with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      seen++;
      if (expq.size() == 0) check(1'b0, "R7 unexpected write", {wr_addr, wr_data}, '0);
      else begin
        logic [95:0] e;
        e = expq.pop_front();
        check({wr_addr, wr_data} === e, "R7/R8/R9 message", {wr_addr, wr_data}, e);
      end
    end
  end

  task automatic cfg_write(input logic [1:0] s, input logic [31:0] v);
    @(negedge clk); cfg_sel = s; cfg_wdata = v; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] s, output logic [31:0] v, output logic [31:0] v32o);
    @(negedge clk); cfg_sel = s; #1; v = cfg_rdata; v32o = rdata32;
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk); irq_req = m;
    @(negedge clk); irq_req = '0;
  endtask

  // expected vector, restated with modular arithmetic
  function automatic logic [7:0] exp_vec(input int vec, input int src, input int n);
    int eff;
    eff = (src >= n) ? n - 1 : src;
    return 8'(vec - (vec % n) + eff);
  endfunction

  localparam logic [63:0] ADDR = 64'h12345678_FEEAB008;

  task automatic expect_msg(input int src, input int n);
    expq.push_back({ADDR, 16'h0000, 8'h41, exp_vec(8'h55, src, n)});
  endtask

  task automatic drain(input string req);
    int t = 0;
    while (expq.size() != 0 && t < 200) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    check(expq.size() == 0, req, 96'(expq.size()), 96'd0);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    check(1'b0, "watchdog", 96'd0, 96'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r, r32;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cfg_read(2'd0, r, r32);
    check(r == 32'h84, "R1 control reset", 96'(r), 96'h84);
    check(r32 == 32'h00, "R1 control reset 32-bit", 96'(r32), 96'h00);
    check(intx_disable == 1'b0, "R10 disable low", 96'(intx_disable), 96'd0);

    cfg_write(2'd0, 32'hFFFF_FFFF);
    cfg_read(2'd0, r, r32);
    check(r == 32'hA5, "R2 count clamp", 96'(r), 96'hA5);
    check(intx_disable == 1'b1, "R10 disable high", 96'(intx_disable), 96'd1);
    cfg_write(2'd0, 32'h0000_0060);
    cfg_read(2'd0, r, r32);
    check(r == 32'hA4, "R2 reserved code clamp", 96'(r), 96'hA4);
    cfg_write(2'd0, 32'h0);

    cfg_write(2'd1, 32'hFFFF_FFFF);
    cfg_read(2'd1, r, r32);
    check(r == 32'hFEEF_F00C, "R3 address low mask", 96'(r), 96'hFEEFF00C);
    cfg_write(2'd1, 32'h000A_B008);
    cfg_read(2'd1, r, r32);
    check(r == 32'hFEEA_B008, "R3 address low value", 96'(r), 96'hFEEAB008);

    cfg_write(2'd2, 32'h1234_5678);
    cfg_read(2'd2, r, r32);
    check(r == 32'h1234_5678, "R4 upper address", 96'(r), 96'h12345678);
    check(r32 == 32'h0, "R4 upper address absent", 96'(r32), 96'd0);

    cfg_write(2'd3, 32'hFFFF_FFFF);
    cfg_read(2'd3, r, r32);
    check(r == 32'h0000_C7FF, "R5 data mask", 96'(r), 96'hC7FF);
    cfg_write(2'd3, 32'h0000_4155);

    // disabled: request must wait
    pulse(8'h04);
    repeat (10) @(negedge clk);
    check(seen == 0 && !wr_valid, "R6 no write while disabled", 96'(seen), 96'd0);
    expect_msg(2, 1);
    cfg_write(2'd0, 32'h0000_0001);
    drain("R6 pending sent after enable");

    // four messages, all sources at once: lowest first, folding
    cfg_write(2'd0, 32'h0000_0021);
    for (int i = 0; i < 8; i++) expect_msg(i, 4);
    pulse(8'hFF);
    drain("R7 R8 all sources served");
    check(seen == 9, "R7 one write per request", 96'(seen), 96'd9);

    // two messages, sources 1 and 3
    cfg_write(2'd0, 32'h0000_0011);
    expect_msg(1, 2);
    expect_msg(3, 2);
    pulse(8'h0A);
    drain("R8 two-message fold");

    // held stall: valid must stay high, nothing accepted
    stall = 1'b1;
    expect_msg(0, 2);
    pulse(8'h01);
    repeat (6) @(negedge clk);
    check(wr_valid == 1'b1 && seen == 11, "R7 hold under stall", {64'(wr_valid), 32'(seen)}, {64'd1, 32'd11});
    stall = 1'b0;
    drain("R7 released after stall");
    check(seen == 12, "R7 total writes", 96'(seen), 96'd12);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule